// File: doc/BRIEF.md
# POST Code Debug LED Controller

This block drives four bicolor debug LEDs. Each LED has its own red and green enable. The LEDs show one of three views. The first is a fixed red fault view, used from power-up until the first byte arrives on the POST capture port. The second is a repeating nibble display of the last captured 8-bit POST code: the high nibble, then the low nibble, then a dark pause, in green only. The third is a direct view in which a software-written control byte sets the color of each LED. A small byte-wide register interface holds a 4-bit configuration field, which selects the view after the fault phase, and the 8-bit direct-control byte.

A phase sequencer steps through `PH_HIGH`, then `PH_LOW`, then `PH_PAUSE`, and back to `PH_HIGH`. It takes one step each time a prescaler of `PHASE_CYCLES` clocks reaches its terminal count. Any POST write forces the sequencer back to `PH_HIGH` with the counter cleared. The display mode is taken from the configuration field only at those two events, a terminal count or a POST write. So a mode change is seen at the next phase boundary. The mode states are `DM_POST`, `DM_DIRECT` and `DM_OFF`. A sticky flag marks that the first POST write has happened. It separates the fault phase from the run phase, and there is no transition back. The LED outputs are registered.

Top module: `dbg_led_ctrl`

## Requirements
- R1: While reset is asserted, every LED output is 0. After reset the configuration register reads 0x01, the direct-control register reads 0x00 and the display mode is direct.
- R2: A read of the configuration address (default 0x290) returns bits 7..4 as 0 and bits 3..0 as the last written field, including reserved values. The direct-control address (default 0x291) reads back all 8 written bits. Any other address reads 0.
- R3: Until the first POST write, LED3 is red when power good is low, LED2 when CPU catastrophic error is high, LED1 when PCI reset is high, and LED0 when boot failure is high. Green is off. This holds whatever the configuration field holds.
- R4: After the first POST write the status inputs no longer affect the LEDs, and no later event returns the block to the fault view.
- R5: With the field at 0000, LED n is green with POST bit n+4 during PH_HIGH, green with POST bit n during PH_LOW, and dark during PH_PAUSE. Each phase lasts PHASE_CYCLES clocks and red stays off.
- R6: A POST write captures the new code and restarts the sequence at PH_HIGH with a full-length phase.
- R7: A change of the configuration field takes effect at the next phase boundary or POST write, not before.
- R8: With the field at 0001, direct-control bit 2n drives the green of LED n and bit 2n+1 drives its red. A change to the direct byte shows without waiting for a phase boundary.
- R9: With the field at any value from 0010 to 1111, all LED outputs are off.
- R10: Every LED output changes exactly one clock after the input or state that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 16 | Register address for reads and writes |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| post_wr | input | 1 | Strobe for a byte written to the POST port |
| post_data | input | 8 | POST code byte |
| pwr_good | input | 1 | Board power good reached |
| cpu_cat_err | input | 1 | CPU catastrophic error |
| pci_rst | input | 1 | PCI reset still asserted |
| boot_fail | input | 1 | Firmware boot failure |
| led_red | output | 4 | Red enable per LED |
| led_green | output | 4 | Green enable per LED |

## Verification
A wrong phase state or a bad prescaler count shows at the outputs. The green pattern moves to the wrong nibble or goes dark too early or too late. The bench sees this on the first cycle after the bad transition, because it compares the LEDs with its own model on every clock. A mode latched at the wrong time shows as an early or late switch of view around a configuration write. A lost fault flag shows as red indicators that follow the status inputs after the first POST write. Each of these shows within one phase length of the event.

// File: rtl/dbg_led_pkg.sv
package dbg_led_pkg;

    typedef enum logic [1:0] {
        PH_HIGH  = 2'd0,
        PH_LOW   = 2'd1,
        PH_PAUSE = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        DM_POST   = 2'd0,
        DM_DIRECT = 2'd1,
        DM_OFF    = 2'd2
    } dmode_e;

    function automatic dmode_e decode_mode(input logic [3:0] field);
        dmode_e m;
        unique case (field)
            4'd0:    m = DM_POST;
            4'd1:    m = DM_DIRECT;
            default: m = DM_OFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dbg_led_regs.sv
module dbg_led_regs #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CFG_W     = 4,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 16'h0290,
    parameter logic [ADDR_W-1:0] DIR_ADDR = 16'h0291,
    parameter logic [CFG_W-1:0]  CFG_RST  = 4'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              post_wr,
    input  logic [DATA_W-1:0] post_data,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [DATA_W-1:0] dir_q,
    output logic [DATA_W-1:0] code_q,
    output logic              seen_q
);
    localparam int unsigned PAD_W = DATA_W - CFG_W;

    logic cfg_hit;
    logic dir_hit;

    assign cfg_hit = (bus_addr == CFG_ADDR);
    assign dir_hit = (bus_addr == DIR_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
            dir_q <= '0;
        end else if (bus_wr) begin
            if (cfg_hit) cfg_q <= bus_wdata[CFG_W-1:0];
            if (dir_hit) dir_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            seen_q <= 1'b0;
        end else if (post_wr) begin
            code_q <= post_data;
            seen_q <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (cfg_hit)      bus_rdata = {{PAD_W{1'b0}}, cfg_q};
        else if (dir_hit) bus_rdata = dir_q;
    end

    // R4: the end of the fault phase is permanent
    a_r4_seen_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |=> seen_q);

    // R6: a POST write lands in the code register on the next edge
    a_r6_code_capture: assert property (@(posedge clk) disable iff (!rst_n)
        post_wr |=> (code_q == $past(post_data)));

endmodule

// File: rtl/dbg_led_seq.sv
module dbg_led_seq
    import dbg_led_pkg::*;
#(
    parameter int unsigned PHASE_CYCLES = 8,
    parameter int unsigned CFG_W        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             post_wr,
    input  logic [CFG_W-1:0] cfg_q,
    output phase_e           phase_q,
    output dmode_e           mode_q
);
    localparam int unsigned CNT_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PHASE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    phase_e           phase_d;

    assign tick = (cnt_q == CNT_LAST);

    // next-state logic of the phase machine
    always_comb begin
        phase_d = phase_q;
        if (post_wr) begin
            phase_d = PH_HIGH;
        end else if (tick) begin
            unique case (phase_q)
                PH_HIGH:  phase_d = PH_LOW;
                PH_LOW:   phase_d = PH_PAUSE;
                PH_PAUSE: phase_d = PH_HIGH;
                default:  phase_d = PH_HIGH;
            endcase
        end
    end

    // state register, prescaler and mode latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
            mode_q  <= DM_DIRECT;
        end else begin
            phase_q <= phase_d;
            if (post_wr || tick) begin
                cnt_q  <= '0;
                mode_q <= decode_mode(4'(cfg_q));
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R5: the prescaler never passes its terminal count
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);

    // R6: a POST write restarts at the high-nibble phase with a full count
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        post_wr |=> (phase_q == PH_HIGH && cnt_q == '0));

    // R7: the mode changes only at a boundary
    a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !post_wr) |=> $stable(mode_q));

    // R5: the phase holds within a phase
    a_r5_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !post_wr) |=> $stable(phase_q));

endmodule

// File: rtl/dbg_led_out.sv
module dbg_led_out
    import dbg_led_pkg::*;
#(
    parameter int unsigned LED_N = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seen_q,
    input  phase_e             phase_q,
    input  dmode_e             mode_q,
    input  logic [2*LED_N-1:0] code_q,
    input  logic [2*LED_N-1:0] dir_q,
    input  logic [LED_N-1:0]   fault_vec,
    output logic [LED_N-1:0]   led_red,
    output logic [LED_N-1:0]   led_green
);
    logic [LED_N-1:0] dir_red;
    logic [LED_N-1:0] dir_green;
    logic [LED_N-1:0] red_d;
    logic [LED_N-1:0] green_d;

    for (genvar n = 0; n < LED_N; n++) begin : g_dir
        assign dir_green[n] = dir_q[2*n];
        assign dir_red[n]   = dir_q[2*n+1];
    end

    always_comb begin
        red_d   = '0;
        green_d = '0;
        if (!seen_q) begin
            red_d = fault_vec;
        end else begin
            unique case (mode_q)
                DM_POST: begin
                    unique case (phase_q)
                        PH_HIGH:  green_d = code_q[2*LED_N-1:LED_N];
                        PH_LOW:   green_d = code_q[LED_N-1:0];
                        default:  green_d = '0;
                    endcase
                end
                DM_DIRECT: begin
                    red_d   = dir_red;
                    green_d = dir_green;
                end
                default: begin
                    red_d   = '0;
                    green_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            led_red   <= '0;
            led_green <= '0;
        end else begin
            led_red   <= red_d;
            led_green <= green_d;
        end
    end

    // R3: no green while fault indicators are shown
    a_r3_fault_no_green: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |=> (led_green == '0));

    // R5: the POST view never lights red
    a_r5_post_no_red: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && mode_q == DM_POST) |=> (led_red == '0));

    // R5: the pause phase is dark
    a_r5_pause_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && mode_q == DM_POST && phase_q == PH_PAUSE) |=> (led_green == '0));

    // R9: a reserved field turns everything off
    a_r9_off: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && mode_q == DM_OFF) |=> (led_red == '0 && led_green == '0));

endmodule

// File: rtl/dbg_led_ctrl.sv
module dbg_led_ctrl
    import dbg_led_pkg::*;
#(
    parameter int unsigned PHASE_CYCLES = 8,
    parameter logic [15:0] CFG_ADDR     = 16'h0290,
    parameter logic [15:0] DIR_ADDR     = 16'h0291
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [15:0] bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        post_wr,
    input  logic [7:0]  post_data,
    input  logic        pwr_good,
    input  logic        cpu_cat_err,
    input  logic        pci_rst,
    input  logic        boot_fail,
    output logic [3:0]  led_red,
    output logic [3:0]  led_green
);
    localparam int unsigned LED_N  = 4;
    localparam int unsigned DATA_W = 2 * LED_N;
    localparam int unsigned CFG_W  = 4;

    logic [CFG_W-1:0]  cfg_q;
    logic [DATA_W-1:0] dir_q;
    logic [DATA_W-1:0] code_q;
    logic              seen_q;
    phase_e            phase_q;
    dmode_e            mode_q;
    logic [LED_N-1:0]  fault_vec;

    assign fault_vec = {~pwr_good, cpu_cat_err, pci_rst, boot_fail};

    dbg_led_regs #(
        .ADDR_W   (16),
        .DATA_W   (DATA_W),
        .CFG_W    (CFG_W),
        .CFG_ADDR (CFG_ADDR),
        .DIR_ADDR (DIR_ADDR),
        .CFG_RST  (4'h1)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .post_wr   (post_wr),
        .post_data (post_data),
        .cfg_q     (cfg_q),
        .dir_q     (dir_q),
        .code_q    (code_q),
        .seen_q    (seen_q)
    );

    dbg_led_seq #(
        .PHASE_CYCLES (PHASE_CYCLES),
        .CFG_W        (CFG_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .post_wr (post_wr),
        .cfg_q   (cfg_q),
        .phase_q (phase_q),
        .mode_q  (mode_q)
    );

    dbg_led_out #(
        .LED_N (LED_N)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .seen_q    (seen_q),
        .phase_q   (phase_q),
        .mode_q    (mode_q),
        .code_q    (code_q),
        .dir_q     (dir_q),
        .fault_vec (fault_vec),
        .led_red   (led_red),
        .led_green (led_green)
    );

    // R4: after the first POST write the status inputs alone cannot change the LEDs
    a_r4_status_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && mode_q == DM_OFF) |=> (led_red == '0));

endmodule

// File: tb/dbg_led_ctrl_bench.sv
module dbg_led_ctrl_bench;
    localparam int P = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        post_wr = 1'b0;
    logic [7:0]  post_data = '0;
    logic        pwr_good = 1'b0;
    logic        cpu_cat_err = 1'b0;
    logic        pci_rst = 1'b0;
    logic        boot_fail = 1'b0;
    logic [3:0]  led_red;
    logic [3:0]  led_green;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    // reference model state
    int m_cfg = 1, m_dir = 0, m_code = 0, m_seen = 0;
    int m_phase = 0, m_cnt = 0, m_mode = 1;
    logic [3:0] m_red = '0, m_green = '0;

    always #4 clk = ~clk;

    dbg_led_ctrl #(.PHASE_CYCLES(P)) u_dbg_led_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .post_wr(post_wr),
        .post_data(post_data), .pwr_good(pwr_good), .cpu_cat_err(cpu_cat_err),
        .pci_rst(pci_rst), .boot_fail(boot_fail), .led_red(led_red),
        .led_green(led_green)
    );

    function automatic int mode_of(input int f);
        return (f == 0) ? 0 : (f == 1) ? 1 : 2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 1; m_dir = 0; m_code = 0; m_seen = 0;
            m_phase = 0; m_cnt = 0; m_mode = 1;
            m_red = '0; m_green = '0;
        end else begin
            m_red = '0; m_green = '0;
            if (m_seen == 0) begin
                m_red = {~pwr_good, cpu_cat_err, pci_rst, boot_fail};
            end else if (m_mode == 0) begin
                if (m_phase == 0)      m_green = 4'((m_code >> 4) & 15);
                else if (m_phase == 1) m_green = 4'(m_code & 15);
            end else if (m_mode == 1) begin
                for (int n = 0; n < 4; n++) begin
                    m_green[n] = m_dir[2*n];
                    m_red[n]   = m_dir[2*n+1];
                end
            end
            if (post_wr) begin
                m_phase = 0; m_cnt = 0; m_mode = mode_of(m_cfg);
            end else if (m_cnt == P - 1) begin
                m_cnt = 0; m_phase = (m_phase + 1) % 3; m_mode = mode_of(m_cfg);
            end else begin
                m_cnt++;
            end
            if (bus_wr && bus_addr == 16'h0290) m_cfg = int'(bus_wdata) & 15;
            if (bus_wr && bus_addr == 16'h0291) m_dir = int'(bus_wdata);
            if (post_wr) begin m_code = int'(post_data); m_seen = 1; end
        end
    end

    // per-cycle comparison against the model (R10 timing is implied by it)
    always @(negedge clk) begin
        checks++;
        if (led_red !== m_red || led_green !== m_green) begin
            failures++;
            $display("FAIL %s/R10 t=%0t red=%b green=%b expected red=%b green=%b",
                     cur_req, $time, led_red, led_green, m_red, m_green);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic post_write(input logic [7:0] d);
        post_data = d; post_wr = 1'b1;
        @(negedge clk);
        post_wr = 1'b0;
    endtask

    task automatic read_check(input logic [15:0] a, input logic [7:0] exp, input string req);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            failures++;
            $display("FAIL %s read 0x%h got 0x%h expected 0x%h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        tick(3);
        read_check(16'h0290, 8'h01, "R1");
        read_check(16'h0291, 8'h00, "R1");
        rst_n = 1'b1;
        tick(2);

        // R3: fault view under several status patterns, any mode
        cur_req = "R3";
        pwr_good = 0; cpu_cat_err = 1; pci_rst = 1; boot_fail = 0; tick(3);
        pwr_good = 1; cpu_cat_err = 0; pci_rst = 0; boot_fail = 1; tick(3);
        bus_write(16'h0290, 8'h00);
        pwr_good = 0; cpu_cat_err = 1; pci_rst = 0; boot_fail = 1; tick(P + 3);
        bus_write(16'h0290, 8'h09);
        pwr_good = 1; cpu_cat_err = 1; pci_rst = 1; boot_fail = 1; tick(P + 3);

        // R2: readback with reserved bits and unknown address
        cur_req = "R2";
        bus_write(16'h0290, 8'hF7);
        read_check(16'h0290, 8'h07, "R2");
        bus_write(16'h0291, 8'hC3);
        read_check(16'h0291, 8'hC3, "R2");
        read_check(16'h0080, 8'h00, "R2");
        bus_write(16'h0290, 8'h00);
        read_check(16'h0290, 8'h00, "R2");
        tick(P + 1);

        // R4 and R5: first POST write, nibble sequence
        cur_req = "R5";
        post_write(8'hA5);
        tick(3 * P + 5);
        cur_req = "R4";
        pwr_good = 0; cpu_cat_err = 0; pci_rst = 1; boot_fail = 0;
        tick(2 * P);

        // R6: restart mid-phase with a new code
        cur_req = "R6";
        tick(3);
        post_write(8'h3C);
        tick(2 * P + 2);
        post_write(8'hF0);
        tick(3 * P);

        // R7 and R8: change to direct mode mid-phase
        cur_req = "R7";
        tick(2);
        bus_write(16'h0290, 8'h01);
        tick(P + 2);
        cur_req = "R8";
        bus_write(16'h0291, 8'h1B);
        tick(3);
        bus_write(16'h0291, 8'hE4);
        tick(3);
        bus_write(16'h0291, 8'hFF);
        tick(P);

        // R9: reserved field turns all off, field still reads back
        cur_req = "R9";
        bus_write(16'h0290, 8'h0D);
        read_check(16'h0290, 8'h0D, "R9");
        tick(P + 2);
        checks++;
        if (led_red !== 4'h0 || led_green !== 4'h0) begin
            failures++;
            $display("FAIL R9 red=%b green=%b expected 0000 0000", led_red, led_green);
        end
        post_write(8'h81);
        tick(P);

        // R5 again with another code after returning to POST mode
        cur_req = "R5";
        bus_write(16'h0290, 8'h00);
        tick(P + 2);
        post_write(8'h69);
        tick(4 * P);

        finish_run();
    end
endmodule